// File: doc/BRIEF.md
# Programmable Address Window Remapper

This block holds the address translation windows for two request sources: the processor and bus-master DMA. Each source owns four windows, and each window is described by three 64-bit registers: a base, a mask and a map. A register port reads and writes these registers by byte offset. Writes land on the next rising clock edge. Reads are combinational.

For each source, a purely combinational lookup takes an incoming address and finds the lowest-numbered window that matches it. It returns the remapped address, a two-bit destination code taken from the winning window's map register, and a hit flag.

Out of reset, processor window 0 sends the first `BOOT_SPAN` bytes to DDR unchanged. Processor window 1 sends the next `BOOT_SPAN` bytes to the bus space at the same addresses. This lets boot code run before software has configured anything. Software later fills the other windows, for example a 1–2 GiB pass-through to the bus or a high DDR window sized to the installed memory.

Top module: `awin_remap`

## Requirements
- R1: The processor lookup uses only the processor windows, and the DMA lookup uses only the DMA windows; a hit in one source's set never affects the other source's outputs.
- R2: Register selection uses `cfg_addr[8:3]`, and `cfg_addr[2:0]` is ignored. Window n sits at group offset + 8·n. The group offsets are: processor base 0x00, processor mask 0x20, processor map 0x40, DMA base 0x60, DMA mask 0x80, DMA map 0xA0.
- R3: A write with `cfg_we` high is visible on `cfg_rdata` and on the lookups only after the next rising clock edge. `cfg_rdata` shows the register selected by `cfg_addr` in the same cycle.
- R4: Offsets 0xC0 to 0x1FF read as zero, and writes to them change no register.
- R5: After reset, processor window 0 has base 0, mask ~(BOOT_SPAN−1) and map 0 (DDR). Processor window 1 has base BOOT_SPAN, mask ~(BOOT_SPAN−1) and map BOOT_SPAN|1 (bus).
- R6: After reset, processor windows 2 and 3 and all DMA windows have base all ones, mask all ones and map zero.
- R7: A window matches when (address AND mask) equals (base AND mask).
- R8: On a hit, the output address is (map AND mask AND NOT 3) OR (address AND NOT mask). The destination code is map[1:0], where code 0 means DDR and code 1 means bus space for the processor or local I/O for DMA.
- R9: When several windows match, the lowest-numbered window wins.
- R10: When no window matches, the hit flag, the output address and the destination code are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data (combinational) |
| cpu_addr_i | input | 64 | Processor address to translate |
| cpu_addr_o | output | 64 | Translated processor address |
| cpu_dst_o | output | 2 | Processor destination code |
| cpu_hit_o | output | 1 | Processor window hit |
| dma_addr_i | input | 64 | DMA address to translate |
| dma_addr_o | output | 64 | Translated DMA address |
| dma_dst_o | output | 2 | DMA destination code |
| dma_hit_o | output | 1 | DMA window hit |

## Verification
The lookup assertions assume that the lookup addresses and the window registers change only between clock edges, because they sample combinational results at the rising edge. The bench changes every input on the falling edge to keep to this. The offset-pass-through check assumes the mask of any programmed window is a contiguous run of ones above a power-of-two boundary of at least 4 bytes. The random stimulus therefore builds each mask as the complement of 2^k−1 with k between 2 and 40, and aligns each base and map to that mask. Directed cases cover overlapping windows, the boot defaults, and writes to unassigned offsets.

// File: rtl/awin_pkg.sv
package awin_pkg;
   localparam int unsigned REG_W  = 64;
   localparam int unsigned GROUPS = 6;

   // group order is the software-visible register layout
   localparam int unsigned GRP_CPU_BASE = 0;
   localparam int unsigned GRP_CPU_MASK = 1;
   localparam int unsigned GRP_CPU_MAP  = 2;
   localparam int unsigned GRP_DMA_BASE = 3;
   localparam int unsigned GRP_DMA_MASK = 4;
   localparam int unsigned GRP_DMA_MAP  = 5;

   localparam logic [1:0] DST_DDR = 2'd0;
   localparam logic [1:0] DST_ALT = 2'd1;

   typedef logic [REG_W-1:0] word_t;

   function automatic word_t span_to_mask(input word_t span);
      return ~(span - word_t'(1));
   endfunction
endpackage

// File: rtl/awin_regfile.sv
module awin_regfile
   import awin_pkg::*;
#(
   parameter int unsigned NUM_WIN   = 4,
   parameter int unsigned OFF_W     = 9,
   parameter logic [63:0] BOOT_SPAN = 64'h0000_0000_1000_0000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [OFF_W-1:0]              cfg_addr,
   input  word_t                         cfg_wdata,
   output word_t                         cfg_rdata,
   output logic [NUM_WIN-1:0][REG_W-1:0] cpu_base_o,
   output logic [NUM_WIN-1:0][REG_W-1:0] cpu_mask_o,
   output logic [NUM_WIN-1:0][REG_W-1:0] cpu_map_o,
   output logic [NUM_WIN-1:0][REG_W-1:0] dma_base_o,
   output logic [NUM_WIN-1:0][REG_W-1:0] dma_mask_o,
   output logic [NUM_WIN-1:0][REG_W-1:0] dma_map_o
);
   localparam int unsigned WIN_B = $clog2(NUM_WIN);
   localparam int unsigned GRP_W = OFF_W - 3 - WIN_B;
   localparam int unsigned NREG  = GROUPS * NUM_WIN;

   word_t                   regs [GROUPS][NUM_WIN];
   logic [GRP_W-1:0]        acc_grp;
   logic [WIN_B-1:0]        acc_win;
   logic                    acc_mapped;
   logic [2:0]              unused_lo;
   logic [NREG*REG_W-1:0]   regs_flat;

   assign acc_grp    = cfg_addr[OFF_W-1:3+WIN_B];
   assign acc_win    = cfg_addr[3+WIN_B-1:3];
   assign acc_mapped = (acc_grp < GRP_W'(GROUPS));
   assign unused_lo  = cfg_addr[2:0];

   function automatic word_t boot_value(input int unsigned g, input int unsigned w);
      word_t v;
      v = '1;
      if (g == GRP_DMA_MAP || g == GRP_CPU_MAP) v = '0;
      if (w < 2) begin
         case (g)
            GRP_CPU_BASE: v = (w == 0) ? '0 : BOOT_SPAN;
            GRP_CPU_MASK: v = span_to_mask(BOOT_SPAN);
            GRP_CPU_MAP:  v = (w == 0) ? {BOOT_SPAN[REG_W-1:2] & '0, DST_DDR}
                                       : (BOOT_SPAN | word_t'(DST_ALT));
            default:      v = v;
         endcase
      end
      return v;
   endfunction

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[g][w] <= boot_value(g, w);
            else if (cfg_we && acc_mapped && acc_grp == GRP_W'(g) && acc_win == WIN_B'(w))
               regs[g][w] <= cfg_wdata;
         end
         assign regs_flat[(g*NUM_WIN+w)*REG_W +: REG_W] = regs[g][w];
      end
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_out
      assign cpu_base_o[w] = regs[GRP_CPU_BASE][w];
      assign cpu_mask_o[w] = regs[GRP_CPU_MASK][w];
      assign cpu_map_o[w]  = regs[GRP_CPU_MAP][w];
      assign dma_base_o[w] = regs[GRP_DMA_BASE][w];
      assign dma_mask_o[w] = regs[GRP_DMA_MASK][w];
      assign dma_map_o[w]  = regs[GRP_DMA_MAP][w];
   end

   always_comb begin
      cfg_rdata = '0;
      for (int g = 0; g < GROUPS; g++) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            if (acc_mapped && acc_grp == GRP_W'(g) && acc_win == WIN_B'(w))
               cfg_rdata = regs[g][w];
         end
      end
   end

   AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !acc_mapped) |=> $stable(regs_flat)); // R4
   AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(regs_flat)); // R3
   AST_WRITE_SEEN_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && acc_mapped) ##1 $stable(cfg_addr) |-> cfg_rdata == $past(cfg_wdata)); // R3
endmodule

// File: rtl/awin_match.sv
module awin_match
   import awin_pkg::*;
(
   input  word_t addr_i,
   input  word_t base_i,
   input  word_t mask_i,
   output logic  match_o
);
   assign match_o = ((addr_i & mask_i) == (base_i & mask_i));
endmodule

// File: rtl/awin_lookup.sv
module awin_lookup
   import awin_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WIN-1:0][REG_W-1:0] base_i,
   input  logic [NUM_WIN-1:0][REG_W-1:0] mask_i,
   input  logic [NUM_WIN-1:0][REG_W-1:0] map_i,
   input  word_t                         addr_i,
   output word_t                         addr_o,
   output logic [1:0]                    dst_o,
   output logic                          hit_o
);
   localparam int unsigned SEL_W = $clog2(NUM_WIN);

   logic [NUM_WIN-1:0] match;
   logic [NUM_WIN-1:0] below_sel;
   logic [SEL_W-1:0]   sel;
   logic               found;
   word_t              sel_mask;
   word_t              sel_map;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      awin_match u_match (
         .addr_i  (addr_i),
         .base_i  (base_i[w]),
         .mask_i  (mask_i[w]),
         .match_o (match[w])
      );
   end

   // scan from the top so the lowest matching index is written last
   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (match[w]) begin
            sel   = SEL_W'(w);
            found = 1'b1;
         end
      end
   end

   assign sel_mask  = mask_i[sel];
   assign sel_map   = map_i[sel];
   assign below_sel = (NUM_WIN'(1) << sel) - NUM_WIN'(1);

   assign hit_o  = found;
   assign addr_o = found ? ((sel_map & sel_mask & ~word_t'(3)) | (addr_i & ~sel_mask)) : '0;
   assign dst_o  = found ? sel_map[1:0] : 2'b00;

   AST_NO_LOWER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (match & below_sel) == '0); // R9
   AST_ANY_MATCH_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (|match) |-> hit_o); // R7
   AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ((addr_o ^ addr_i) & ~mask_i[sel]) == '0); // R8
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (addr_o == '0 && dst_o == 2'b00)); // R10
endmodule

// File: rtl/awin_remap.sv
module awin_remap
   import awin_pkg::*;
#(
   parameter int unsigned NUM_WIN   = 4,
   parameter int unsigned OFF_W     = 9,
   parameter logic [63:0] BOOT_SPAN = 64'h0000_0000_1000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [OFF_W-1:0] cfg_addr,
   input  logic [63:0]      cfg_wdata,
   output logic [63:0]      cfg_rdata,
   input  logic [63:0]      cpu_addr_i,
   output logic [63:0]      cpu_addr_o,
   output logic [1:0]       cpu_dst_o,
   output logic             cpu_hit_o,
   input  logic [63:0]      dma_addr_i,
   output logic [63:0]      dma_addr_o,
   output logic [1:0]       dma_dst_o,
   output logic             dma_hit_o
);
   if (NUM_WIN < 2 || (NUM_WIN & (NUM_WIN - 1)) != 0) begin : g_bad_win
      $error("NUM_WIN must be a power of two of at least 2");
   end
   if (GROUPS * NUM_WIN * 8 > (1 << OFF_W)) begin : g_bad_off
      $error("OFF_W too small for the register groups");
   end
   if ((BOOT_SPAN & (BOOT_SPAN - 64'd1)) != 64'd0 || BOOT_SPAN < 64'd4) begin : g_bad_span
      $error("BOOT_SPAN must be a power of two of at least 4");
   end

   logic [NUM_WIN-1:0][REG_W-1:0] cpu_base, cpu_mask, cpu_map;
   logic [NUM_WIN-1:0][REG_W-1:0] dma_base, dma_mask, dma_map;

   awin_regfile #(.NUM_WIN(NUM_WIN), .OFF_W(OFF_W), .BOOT_SPAN(BOOT_SPAN)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .cpu_base_o (cpu_base),
      .cpu_mask_o (cpu_mask),
      .cpu_map_o  (cpu_map),
      .dma_base_o (dma_base),
      .dma_mask_o (dma_mask),
      .dma_map_o  (dma_map)
   );

   awin_lookup #(.NUM_WIN(NUM_WIN)) u_cpu_lu (
      .clk    (clk),
      .rst_n  (rst_n),
      .base_i (cpu_base),
      .mask_i (cpu_mask),
      .map_i  (cpu_map),
      .addr_i (cpu_addr_i),
      .addr_o (cpu_addr_o),
      .dst_o  (cpu_dst_o),
      .hit_o  (cpu_hit_o)
   );

   awin_lookup #(.NUM_WIN(NUM_WIN)) u_dma_lu (
      .clk    (clk),
      .rst_n  (rst_n),
      .base_i (dma_base),
      .mask_i (dma_mask),
      .map_i  (dma_map),
      .addr_i (dma_addr_i),
      .addr_o (dma_addr_o),
      .dst_o  (dma_dst_o),
      .hit_o  (dma_hit_o)
   );
endmodule

// File: tb/awin_remap_test.sv
module awin_remap_test;
   localparam int unsigned NW = 4;
   localparam logic [63:0] SPAN = 64'h1000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [8:0]  cfg_addr = '0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] cfg_rdata;
   logic [63:0] cpu_addr_i = '0, cpu_addr_o, dma_addr_i = '0, dma_addr_o;
   logic [1:0]  cpu_dst_o, dma_dst_o;
   logic        cpu_hit_o, dma_hit_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [63:0] mdl [6][NW];

   always #4 clk = ~clk;

   awin_remap uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cpu_addr_i(cpu_addr_i), .cpu_addr_o(cpu_addr_o), .cpu_dst_o(cpu_dst_o), .cpu_hit_o(cpu_hit_o),
      .dma_addr_i(dma_addr_i), .dma_addr_o(dma_addr_o), .dma_dst_o(dma_dst_o), .dma_hit_o(dma_hit_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [8:0] off, input logic [63:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = off; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (off[8:5] < 6) mdl[off[8:5]][off[4:3]] = data;
   endtask

   task automatic read_check(input logic [8:0] off, input string req);
      logic [63:0] exp;
      @(negedge clk);
      cfg_addr = off;
      #1;
      exp = (off[8:5] < 6) ? mdl[off[8:5]][off[4:3]] : 64'd0;
      check(cfg_rdata === exp, req, cfg_rdata, exp);
   endtask

   function automatic void ref_lookup(input int src, input logic [63:0] a,
                                      output logic h, output logic [1:0] d, output logic [63:0] o);
      logic [63:0] b, m, p;
      h = 1'b0; d = 2'd0; o = 64'd0;
      for (int w = NW - 1; w >= 0; w--) begin
         b = mdl[src*3][w]; m = mdl[src*3+1][w]; p = mdl[src*3+2][w];
         if ((a & m) == (b & m)) begin
            h = 1'b1; d = p[1:0]; o = (p & m & ~64'h3) | (a & ~m);
         end
      end
   endfunction

   task automatic lookup_check(input int src, input logic [63:0] a, input string req);
      logic h; logic [1:0] d; logic [63:0] o;
      @(negedge clk);
      if (src == 0) cpu_addr_i = a; else dma_addr_i = a;
      #1;
      ref_lookup(src, a, h, d, o);
      if (src == 0) begin
         check(cpu_hit_o === h, {req, " cpu hit"}, 64'(cpu_hit_o), 64'(h));
         check(cpu_addr_o === o && cpu_dst_o === d, {req, " cpu addr/dst"}, cpu_addr_o ^ 64'(cpu_dst_o), o ^ 64'(d));
      end else begin
         check(dma_hit_o === h, {req, " dma hit"}, 64'(dma_hit_o), 64'(h));
         check(dma_addr_o === o && dma_dst_o === d, {req, " dma addr/dst"}, dma_addr_o ^ 64'(dma_dst_o), o ^ 64'(d));
      end
   endtask

   task automatic check_all_regs(input string req);
      for (int g = 0; g < 6; g++)
         for (int w = 0; w < NW; w++)
            read_check(9'((g << 5) | (w << 3)), req);
   endtask

   initial begin
      #(64'd8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] old, sz, msk, bs, mp;
      int k;
      void'($urandom(32'd4711));
      // expected boot state per R5 and R6
      for (int g = 0; g < 6; g++)
         for (int w = 0; w < NW; w++)
            mdl[g][w] = (g == 2 || g == 5) ? 64'd0 : '1;
      mdl[0][0] = 64'd0;  mdl[1][0] = ~(SPAN - 1); mdl[2][0] = 64'd0;
      mdl[0][1] = SPAN;   mdl[1][1] = ~(SPAN - 1); mdl[2][1] = SPAN | 64'd1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int w = 0; w < 2; w++)
         for (int g = 0; g < 3; g++) read_check(9'((g << 5) | (w << 3)), "R5");
      check_all_regs("R6");
      read_check(9'h0C0, "R4");
      read_check(9'h1F8, "R4");

      lookup_check(0, 64'h0800_0123, "R5");
      lookup_check(0, 64'h1800_0040, "R5");
      lookup_check(0, 64'h3000_0000, "R10");
      lookup_check(1, 64'h0800_0000, "R1");
      lookup_check(1, 64'h4000_0000, "R6");

      // R3: write not visible before the edge, visible after
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 9'h010; cfg_wdata = 64'hFFFF_FFFF_C000_0000;
      #1;
      check(cfg_rdata === mdl[0][2], "R3 before edge", cfg_rdata, mdl[0][2]);
      @(negedge clk);
      cfg_we = 1'b0;
      mdl[0][2] = 64'hFFFF_FFFF_C000_0000;
      #1;
      check(cfg_rdata === 64'hFFFF_FFFF_C000_0000, "R3 after edge", cfg_rdata, 64'hFFFF_FFFF_C000_0000);

      // R2: low offset bits ignored
      cfg_write(9'h035, 64'hFFFF_FFFF_C000_0000);
      read_check(9'h030, "R2");
      cfg_write(9'h052, 64'h4000_0001);
      read_check(9'h050, "R2");
      cfg_write(9'h010, 64'h4000_0000);
      lookup_check(0, 64'h5234_5678, "R8");
      lookup_check(0, 64'h7FFF_FFFC, "R8");

      // R4: unassigned writes change nothing
      cfg_write(9'h0C0, 64'hDEAD_BEEF_0000_0000);
      cfg_write(9'h1FF, 64'h1234_5678_9ABC_DEF0);
      read_check(9'h0C0, "R4");
      check_all_regs("R4");

      // high DDR window, 512 MiB
      cfg_write(9'h018, 64'h8000_0000);
      cfg_write(9'h038, ~(64'h2000_0000 - 1));
      cfg_write(9'h058, 64'h8000_0000);
      lookup_check(0, 64'h9000_0010, "R7");
      lookup_check(0, 64'hB000_0000, "R10");

      // R9: window 2 widened to overlap windows 0 and 1
      cfg_write(9'h010, 64'h0);
      cfg_write(9'h030, ~(64'h8000_0000 - 1));
      lookup_check(0, 64'h0800_0000, "R9");
      lookup_check(0, 64'h1C00_0000, "R9");
      lookup_check(0, 64'h2C00_0000, "R9");

      // DMA window to local I/O
      cfg_write(9'h060, 64'h0);
      cfg_write(9'h080, ~(64'h1000_0000 - 1));
      cfg_write(9'h0A0, 64'h2_0000_0001);
      lookup_check(1, 64'h0ABC_DEF0, "R8");
      lookup_check(0, 64'h0ABC_DEF0, "R1");

      // random windows and lookups
      for (int it = 0; it < 300; it++) begin
         int src, w;
         src = $urandom_range(1, 0);
         w   = $urandom_range(NW - 1, 0);
         k   = $urandom_range(40, 2);
         sz  = 64'd1 << k;
         msk = ~(sz - 1);
         bs  = {$urandom, $urandom} & msk;
         mp  = ({$urandom, $urandom} & msk) | 64'($urandom_range(1, 0));
         cfg_write(9'((src*3)   << 5 | w << 3), bs);
         cfg_write(9'((src*3+1) << 5 | w << 3), msk);
         cfg_write(9'((src*3+2) << 5 | w << 3), mp);
         for (int j = 0; j < 3; j++) begin
            old = (j == 0) ? {$urandom, $urandom} : (bs | ({$urandom, $urandom} & ~msk));
            lookup_check(src, old, "R7");
         end
         if (it % 25 == 0) read_check(9'($urandom_range(511, 0)), "R2");
      end
      check_all_regs("R3");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule